// File: doc/BRIEF.md
# Shared-Term Carry Select Adder

This block adds two unsigned binary operands and an incoming carry. It produces a sum of the same width and a carry-out. It is built as a chain of identical one-bit carry-select cells, sixteen of them at the default width. Every cell forms one exclusive-OR of its two operand bits. That single term is used twice: directly as the sum candidate for the case where no carry arrives, and inverted as the sum candidate for the case where a carry arrives. The carry candidates are the AND of the two bits (no carry arriving) and the OR of the two bits (carry arriving). Two small multiplexers in each cell then let the real incoming carry pick the sum bit and the carry handed to the next cell.

The block is purely combinational. It holds no registers and has no clock or reset. It fits wherever a compact adder is wanted and a carry path through one multiplexer per bit is acceptable. The external carry-in steers the lowest cell. The carry picked in the highest cell leaves the block as the carry-out.

Top module: `csa_adder16`

## Requirements
- R1: For every input combination, {carry_out, sum_out} equals the (WIDTH+1)-bit value a_opnd + b_opnd + carry_in.
- R2: With carry_in = 0 and no bit position where both operands are 1, sum_out equals a_opnd OR b_opnd and carry_out is 0, because every cell takes its no-carry candidates (exclusive-OR for the sum, AND for the carry).
- R3: With b_opnd equal to the bitwise inverse of a_opnd, every cell propagates its carry. The result is sum_out = 0 and carry_out = 1 when carry_in = 1, and sum_out = all ones and carry_out = 0 when carry_in = 0. This exercises the path through all sixteen carry multiplexers (for example 0xFFFF + 0x0000 with carry-in 1).
- R4: With both operands zero, sum_out equals carry_in in bit 0 and zero elsewhere, and carry_out is 0, since the external carry steers the lowest cell.
- R5: All ones plus one (0xFFFF + 0x0001, carry_in = 0) gives sum_out = 0x0000 and carry_out = 1.
- R6: Alternating bit patterns add correctly: 0xAAAA + 0x5555 gives 0xFFFF with carry_out 0 (carry_in 0), and 0xAAAA + 0xAAAA gives 0x5554 with carry_out 1.
- R7: Outputs follow input changes with no clock edge; a new input value is reflected 1 ns after it is applied.
- R8: When bit 15 of both operands is 1, carry_out is 1, because the carry selected in the top cell is the block's carry-out (0x8000 + 0x8000 gives sum 0x0000, carry_out 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_opnd | input | 16 | First operand |
| b_opnd | input | 16 | Second operand |
| carry_in | input | 1 | Carry into the lowest cell |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry selected by the highest cell |

## Verification
In every cell, the shared exclusive-OR term feeds both the no-carry and the carry-arriving candidates. The two selections therefore happen in the same evaluation, and a fault in one case can hide behind correct results in the other. The bench separates them with vectors whose bit patterns force every cell onto a single candidate pair: disjoint operands with no carry in, and complementary operands with a carry in. It also applies mixed directed and random vectors where both kinds of cell occur within one addition. Each result is judged against an independent wide integer sum, and the checker additionally compares each internal carry against the majority of the operand bits and the carry below.

// File: rtl/csa_pkg.sv
package csa_pkg;
  parameter int unsigned CSA_WIDTH = 16;

  typedef struct packed {
    logic sum;
    logic carry;
  } csa_cand_t;
endpackage

// File: rtl/csa_mux2.sv
module csa_mux2 #(
  parameter int unsigned W = 1
) (
  input  logic [W-1:0] d_zero,
  input  logic [W-1:0] d_one,
  input  logic         sel,
  output logic [W-1:0] q
);
  always_comb q = sel ? d_one : d_zero;
endmodule

// File: rtl/csa_cell.sv
module csa_cell
  import csa_pkg::*;
(
  input  logic bit_a,
  input  logic bit_b,
  input  logic c_in,
  output logic s_bit,
  output logic c_out
);
  logic      x_shared;
  csa_cand_t cand_lo;   // incoming carry assumed 0
  csa_cand_t cand_hi;   // incoming carry assumed 1

  always_comb begin
    x_shared      = bit_a ^ bit_b;
    cand_lo.sum   = x_shared;
    cand_lo.carry = bit_a & bit_b;
    cand_hi.sum   = ~x_shared;
    cand_hi.carry = bit_a | bit_b;
  end

  csa_mux2 #(.W(1)) u_sum_mux (
    .d_zero(cand_lo.sum),
    .d_one (cand_hi.sum),
    .sel   (c_in),
    .q     (s_bit)
  );

  csa_mux2 #(.W(1)) u_carry_mux (
    .d_zero(cand_lo.carry),
    .d_one (cand_hi.carry),
    .sel   (c_in),
    .q     (c_out)
  );
endmodule

// File: rtl/csa_chain.sv
module csa_chain #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             c_first,
  output logic [WIDTH-1:0] s_vec,
  output logic [WIDTH:0]   c_vec
);
  assign c_vec[0] = c_first;

  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    csa_cell u_cell (
      .bit_a(op_a[g]),
      .bit_b(op_b[g]),
      .c_in (c_vec[g]),
      .s_bit(s_vec[g]),
      .c_out(c_vec[g+1])
    );
  end
endmodule

// File: rtl/csa_adder16.sv
module csa_adder16 #(
  parameter int unsigned WIDTH = csa_pkg::CSA_WIDTH
) (
  input  logic [WIDTH-1:0] a_opnd,
  input  logic [WIDTH-1:0] b_opnd,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  logic [WIDTH:0] ripple;

  csa_chain #(.WIDTH(WIDTH)) u_chain (
    .op_a   (a_opnd),
    .op_b   (b_opnd),
    .c_first(carry_in),
    .s_vec  (sum_out),
    .c_vec  (ripple)
  );

  assign carry_out = ripple[WIDTH];
endmodule

// File: rtl/csa_adder16_chk.sv
module csa_adder16_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a_opnd,
  input logic [WIDTH-1:0] b_opnd,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             carry_out,
  input logic [WIDTH:0]   ripple
);
  logic [WIDTH:0] wide_ref;
  always_comb wide_ref = {1'b0, a_opnd} + {1'b0, b_opnd} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    if (!$isunknown({a_opnd, b_opnd, carry_in, sum_out, carry_out, ripple})) begin
      assert_total_R1: assert ({carry_out, sum_out} == wide_ref)
        else $error("R1 total mismatch");
      for (int i = 0; i < WIDTH; i++) begin
        assert_chain_R1: assert (ripple[i+1] ==
          ((a_opnd[i] & b_opnd[i]) | ((a_opnd[i] | b_opnd[i]) & ripple[i])))
          else $error("R1 carry chain at bit %0d", i);
      end
      if (!carry_in && ((a_opnd & b_opnd) == '0))
        assert_nogen_R2: assert (!carry_out && sum_out == (a_opnd | b_opnd))
          else $error("R2 no-carry candidates");
      if (b_opnd == ~a_opnd)
        assert_prop_R3: assert (carry_out == carry_in && sum_out == {WIDTH{~carry_in}})
          else $error("R3 full propagate");
      if (a_opnd == '0 && b_opnd == '0)
        assert_cin_R4: assert (!carry_out && sum_out == {{(WIDTH-1){1'b0}}, carry_in})
          else $error("R4 carry-in steering");
      if (a_opnd[WIDTH-1] && b_opnd[WIDTH-1])
        assert_top_R8: assert (carry_out)
          else $error("R8 top carry");
    end
  end
endmodule

bind csa_adder16 csa_adder16_chk #(.WIDTH(WIDTH)) u_chk (
  .a_opnd   (a_opnd),
  .b_opnd   (b_opnd),
  .carry_in (carry_in),
  .sum_out  (sum_out),
  .carry_out(carry_out),
  .ripple   (ripple)
);

// File: tb/sim_csa_adder16.sv
`timescale 1ns/1ps
module sim_csa_adder16;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int WATCHDOG_CYCLES = 200000;

  typedef struct {
    logic [W:0] exp;
    string      tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_opnd;
  logic [W-1:0] b_opnd;
  logic         carry_in;
  logic [W-1:0] sum_out;
  logic         carry_out;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_adder16 #(.WIDTH(W)) u0 (
    .a_opnd   (a_opnd),
    .b_opnd   (b_opnd),
    .carry_in (carry_in),
    .sum_out  (sum_out),
    .carry_out(carry_out)
  );

  function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic check(string tag, logic [W:0] act, logic [W:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic c, string tag);
    item_t it;
    @(posedge clk);
    a_opnd   = x;
    b_opnd   = y;
    carry_in = c;
    it.exp = ref_add(x, y, c);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, {carry_out, sum_out}, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    a_opnd = '0; b_opnd = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // quiescent state: zero operands, no carry (R4)
    #1 check("R4 idle zero", {carry_out, sum_out}, 17'h0);

    drive(16'h0000, 16'h0000, 1'b1, "R4 zero plus zero with carry");
    drive(16'h0000, 16'h0000, 1'b0, "R4 zero plus zero");
    drive(16'hF0F0, 16'h0F0F, 1'b0, "R2 disjoint nibbles");
    drive(16'h1248, 16'h8421, 1'b0, "R2 disjoint sparse");
    drive(16'hFFFF, 16'h0000, 1'b1, "R3 ripple all stages");
    drive(16'h0000, 16'hFFFF, 1'b1, "R3 ripple swapped");
    drive(16'h3C5A, 16'hC3A5, 1'b1, "R3 complement with carry");
    drive(16'h3C5A, 16'hC3A5, 1'b0, "R3 complement no carry");
    drive(16'hFFFF, 16'h0001, 1'b0, "R5 all ones plus one");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R5 all ones both plus carry");
    drive(16'hAAAA, 16'h5555, 1'b0, "R6 alternating complement");
    drive(16'hAAAA, 16'hAAAA, 1'b0, "R6 alternating same");
    drive(16'h5555, 16'h5555, 1'b1, "R6 alternating odd with carry");
    drive(16'h8000, 16'h8000, 1'b0, "R8 top bits");
    drive(16'h8000, 16'hFFFF, 1'b1, "R8 top bits with carry");
    for (int i = 0; i < 6000; i++)
      drive(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
    @(posedge clk);
    @(negedge clk);

    // R7: no clock edge needed, output follows 1 ns after the change
    @(negedge clk);
    #2;
    a_opnd = 16'h1234; b_opnd = 16'h4321; carry_in = 1'b1;
    #1 check("R7 immediate update", {carry_out, sum_out}, ref_add(16'h1234, 16'h4321, 1'b1));
    a_opnd = 16'hFFFF; b_opnd = 16'h0000; carry_in = 1'b1;
    #1 check("R7 immediate ripple", {carry_out, sum_out}, 17'h10000);
    // explicit expected values for directed corners
    a_opnd = 16'hAAAA; b_opnd = 16'hAAAA; carry_in = 1'b0;
    #1 check("R6 literal 0x5554", {carry_out, sum_out}, 17'h15554);
    a_opnd = 16'hFFFF; b_opnd = 16'h0001; carry_in = 1'b0;
    #1 check("R5 literal zero", {carry_out, sum_out}, 17'h10000);

    finish_run();
  end
endmodule